// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the status and control word of one downstream port of a root hub. Software reads and writes a single 16-bit word over a plain register bus: `wr_en` with `wr_data` writes it in one clock, and `rd_data` always shows the current contents. Device-side conditions enter on plain inputs: attach, low speed, the overcurrent pin and a remote wakeup request. They are sampled into the word, and each transition of interest is latched as a sticky change flag.

The block also orders the hardware side effects of port control. Entering reset takes an enabled port down and flags the enable change. Leaving reset flags a connect change. Resume signalling can only start on an enabled port. When software ends a resume, the resume bit stays set for a fixed number of microseconds while the end-of-packet is sent. A free-running divider produces the microsecond tick.

Bit map: 0 connected, 1 connect change, 2 enabled, 3 enable change, 4 low speed, 6 resume, 8 overcurrent, 9 reset, 10 overcurrent change, 12 suspend. Bits 5, 7 and 11 are reserved. Bits 13 to 15 are unused.

Top module: `port_status_reg`

## Requirements
- R1: Bit 0 shows `dev_attach` one clock after it is sampled. Every change of `dev_attach` sets bit 1 (connect change).
- R2: Bits 1, 3 and 10 are sticky. A write with a one in the bit clears it, and a zero leaves it unchanged. A setting event in the same clock as a clearing write wins.
- R3: A write sets bit 2 (enabled) only while connected and only when bit 9 is not written as one. A write with bit 2 at zero clears it. A disconnect clears bit 2 and, if the port was enabled, sets bit 3.
- R4: A write that raises bit 9 (reset) while the port is enabled clears bit 2 and sets bit 3. Bit 2 reads zero for as long as bit 9 is set.
- R5: A write that takes bit 9 from one to zero sets bit 1.
- R6: Bit 8 shows `oc_pin`, inverted when `OC_ACTIVE_LOW` is 1, one clock later. Every change of bit 8 sets bit 10.
- R7: A write of one to bit 6 (resume) while bit 2 is zero leaves bit 6 at zero.
- R8: Bit 12 (suspend) holds the last written value. A `wake_req` pulse while bits 12 and 2 are set sets bit 6.
- R9: A write with bit 6 at zero while bit 6 is set leaves bit 6 set until `EOP_US` microsecond ticks have passed, counting from the clock after that write. It then clears. Writes to bit 6 in that time are ignored. A tick occurs every `CLK_PER_US` clocks, counted from reset release.
- R10: Bit 4 shows `dev_low_speed` while connected and reads zero when not connected.
- R11: Bits 5, 7, 11 and 13 to 15 always read zero, whatever is written.
- R12: During reset and directly after it, with inputs idle, the word reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current word |
| dev_attach | input | 1 | Device present on the port |
| dev_low_speed | input | 1 | Attached device is low speed |
| oc_pin | input | 1 | Overcurrent sense pin, polarity set by parameter |
| wake_req | input | 1 | Remote wakeup from the device |

## Verification
The assertions assume that the device inputs are already synchronous to `clk`. They also assume that `wake_req` and writes are single-clock events with no relation required between them. The stimulus changes every input on the falling edge, so each value is stable for a full cycle before it is sampled. The end-of-packet checks assume software does not restart a resume while one is still draining. The bench tries such a write on purpose and expects it to be ignored. A cycle-accurate reference model follows the same microsecond tick phase from reset, which lets it predict the exact clock on which resume clears.

// File: rtl/usbport_pkg.sv
package usbport_pkg;
  localparam int WORD_W     = 16;
  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_LS       = 4;
  localparam int B_RES      = 6;
  localparam int B_OC       = 8;
  localparam int B_RST      = 9;
  localparam int B_OC_CHG   = 10;
  localparam int B_SUSP     = 12;

  typedef struct packed {
    logic conn;
    logic conn_chg;
    logic en;
    logic en_chg;
    logic ls;
    logic resume;
    logic oc;
    logic rst;
    logic oc_chg;
    logic susp;
  } port_state_t;

  // Assemble the readable word; every unlisted position stays zero.
  function automatic logic [WORD_W-1:0] pack_word(port_state_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_CONN]     = s.conn;
    w[B_CONN_CHG] = s.conn_chg;
    w[B_EN]       = s.en;
    w[B_EN_CHG]   = s.en_chg;
    w[B_LS]       = s.ls & s.conn;
    w[B_RES]      = s.resume;
    w[B_OC]       = s.oc;
    w[B_RST]      = s.rst;
    w[B_OC_CHG]   = s.oc_chg;
    w[B_SUSP]     = s.susp;
    return w;
  endfunction

  // Sticky flag: a hardware event sets it, a one written clears it, set wins.
  function automatic logic sticky_next(logic cur, logic set_evt, logic wr_one);
    return set_evt | (cur & ~wr_one);
  endfunction
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  assign us_tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (us_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/port_line_sampler.sv
module port_line_sampler #(
  parameter bit OC_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_attach,
  input  logic dev_low_speed,
  input  logic oc_pin,
  output logic conn_q,
  output logic ls_q,
  output logic oc_q,
  output logic conn_evt,
  output logic conn_fall,
  output logic oc_evt
);
  logic oc_lvl;

  assign oc_lvl    = oc_pin ^ OC_ACTIVE_LOW;
  assign conn_evt  = dev_attach ^ conn_q;
  assign conn_fall = conn_q & ~dev_attach;
  assign oc_evt    = oc_lvl ^ oc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      ls_q   <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      conn_q <= dev_attach;
      ls_q   <= dev_low_speed;
      oc_q   <= oc_lvl;
    end
  end

  p_conn_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conn_evt |=> (conn_q != $past(conn_q)));
endmodule

// File: rtl/resume_eop_seq.sv
module resume_eop_seq #(
  parameter int EOP_US = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic us_tick,
  output logic busy,
  output logic done
);
  localparam int NW = (EOP_US > 1) ? $clog2(EOP_US) : 1;
  localparam logic [NW-1:0] LAST = NW'(EOP_US - 1);

  logic [NW-1:0] ticks;

  assign done = busy & us_tick & (ticks == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ticks <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ticks <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      ticks <= '0;
    end else if (busy && us_tick) begin
      ticks <= ticks + 1'b1;
    end
  end

  p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_end_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(us_tick));
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
  import usbport_pkg::*;
#(
  parameter int CLK_PER_US    = 50,
  parameter int EOP_US        = 2,
  parameter bit OC_ACTIVE_LOW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        dev_attach,
  input  logic        dev_low_speed,
  input  logic        oc_pin,
  input  logic        wake_req
);
  logic us_tick;
  logic conn_q, ls_q, oc_q, conn_evt, conn_fall, oc_evt;
  logic eop_busy, eop_done;

  logic conn_chg_q, en_q, en_chg_q, resume_q, rst_q, oc_chg_q, susp_q;

  // named internal events
  logic rst_rise, rst_release, en_lost, res_wr_clear, res_wr_set, wake_hit;
  logic en_next, resume_next;
  port_state_t st;
  logic unused_wr_bits;

  us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick)
  );

  port_line_sampler #(.OC_ACTIVE_LOW(OC_ACTIVE_LOW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .dev_attach(dev_attach), .dev_low_speed(dev_low_speed), .oc_pin(oc_pin),
    .conn_q(conn_q), .ls_q(ls_q), .oc_q(oc_q),
    .conn_evt(conn_evt), .conn_fall(conn_fall), .oc_evt(oc_evt)
  );

  resume_eop_seq #(.EOP_US(EOP_US)) u_eop (
    .clk(clk), .rst_n(rst_n), .start(res_wr_clear), .us_tick(us_tick),
    .busy(eop_busy), .done(eop_done)
  );

  assign unused_wr_bits = ^{wr_data[15:13], wr_data[11], wr_data[7], wr_data[5], wr_data[0], wr_data[4], wr_data[8]};

  assign rst_rise     = wr_en & wr_data[B_RST] & ~rst_q;
  assign rst_release  = wr_en & ~wr_data[B_RST] & rst_q;
  assign en_lost      = en_q & (conn_fall | rst_rise);
  assign res_wr_clear = wr_en & resume_q & ~wr_data[B_RES] & ~eop_busy;
  assign res_wr_set   = wr_en & wr_data[B_RES] & en_q & ~eop_busy;
  assign wake_hit     = wake_req & susp_q & en_q;

  always_comb begin
    if (conn_fall)  en_next = 1'b0;
    else if (wr_en) en_next = wr_data[B_EN] & conn_q & ~wr_data[B_RST];
    else            en_next = en_q;
  end

  always_comb begin
    if (eop_done)                        resume_next = 1'b0;
    else if (eop_busy || res_wr_clear)   resume_next = resume_q;
    else if (res_wr_set || wake_hit)     resume_next = 1'b1;
    else                                 resume_next = resume_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_chg_q <= 1'b0;
      en_q       <= 1'b0;
      en_chg_q   <= 1'b0;
      resume_q   <= 1'b0;
      rst_q      <= 1'b0;
      oc_chg_q   <= 1'b0;
      susp_q     <= 1'b0;
    end else begin
      conn_chg_q <= sticky_next(conn_chg_q, conn_evt | rst_release,
                                wr_en & wr_data[B_CONN_CHG]);
      en_chg_q   <= sticky_next(en_chg_q, en_lost, wr_en & wr_data[B_EN_CHG]);
      oc_chg_q   <= sticky_next(oc_chg_q, oc_evt, wr_en & wr_data[B_OC_CHG]);
      en_q       <= en_next;
      resume_q   <= resume_next;
      if (wr_en) begin
        rst_q  <= wr_data[B_RST];
        susp_q <= wr_data[B_SUSP];
      end
    end
  end

  always_comb begin
    st.conn     = conn_q;
    st.conn_chg = conn_chg_q;
    st.en       = en_q;
    st.en_chg   = en_chg_q;
    st.ls       = ls_q;
    st.resume   = resume_q;
    st.oc       = oc_q;
    st.rst      = rst_q;
    st.oc_chg   = oc_chg_q;
    st.susp     = susp_q;
  end

  assign rd_data = pack_word(st);

  p_conn_chg_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conn_evt |=> conn_chg_q);
  p_reset_holds_en_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !en_q);
  p_release_flags_conn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_q && !wr_data[B_RST]) |=> conn_chg_q);
  p_oc_chg_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt |=> oc_chg_q);
  p_resume_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q && !$past(resume_q)) |-> $past(en_q));
  p_eop_holds_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eop_busy |-> resume_q);
  p_ls_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !conn_q |-> !rd_data[B_LS]);
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:13] == 3'b000 && !rd_data[11] && !rd_data[7] && !rd_data[5]);
endmodule

// File: tb/port_status_reg_test.sv
module port_status_reg_test;
  localparam int CPU    = 8;
  localparam int EOPU   = 2;
  localparam bit OC_LOW = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        dev_attach = 1'b0;
  logic        dev_low_speed = 1'b0;
  logic        oc_pin = 1'b1;
  logic        wake_req = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  port_status_reg #(.CLK_PER_US(CPU), .EOP_US(EOPU), .OC_ACTIVE_LOW(OC_LOW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_attach(dev_attach), .dev_low_speed(dev_low_speed), .oc_pin(oc_pin),
    .wake_req(wake_req)
  );

  // behavioural reference model
  bit m_c, m_cc, m_e, m_ec, m_ls, m_r, m_o, m_oc, m_rs, m_su;
  int m_cyc, m_left;
  bit m_valid = 0;

  always @(posedge clk) begin
    bit tick, att, ocl, disc, up, dn;
    if (!rst_n) begin
      {m_c, m_cc, m_e, m_ec, m_ls, m_r, m_o, m_oc, m_rs, m_su} = '0;
      m_cyc = 0; m_left = 0; m_valid = 1;
    end else begin
      tick = ((m_cyc % CPU) == CPU - 1);
      m_cyc++;
      att  = dev_attach;
      ocl  = OC_LOW ? !oc_pin : oc_pin;
      disc = m_c && !att;
      up   = wr_en && wr_data[9] && !m_rs;
      dn   = wr_en && !wr_data[9] && m_rs;
      if (m_left > 0) begin
        if (tick) begin
          m_left--;
          if (m_left == 0) m_r = 0;
        end
      end else if (wr_en && m_r && !wr_data[6]) m_left = EOPU;
      else if ((wr_en && wr_data[6] && m_e) || (wake_req && m_su && m_e)) m_r = 1;
      if ((att != m_c) || dn) m_cc = 1; else if (wr_en && wr_data[1]) m_cc = 0;
      if (m_e && (disc || up)) m_ec = 1; else if (wr_en && wr_data[3]) m_ec = 0;
      if (ocl != m_o) m_oc = 1; else if (wr_en && wr_data[10]) m_oc = 0;
      if (disc) m_e = 0; else if (wr_en) m_e = wr_data[2] && m_c && !wr_data[9];
      if (wr_en) begin m_rs = wr_data[9]; m_su = wr_data[12]; end
      m_c = att; m_ls = dev_low_speed; m_o = ocl;
    end
  end

  function automatic logic [15:0] model_word();
    logic [15:0] w = '0;
    w[0] = m_c; w[1] = m_cc; w[2] = m_e; w[3] = m_ec; w[4] = m_ls && m_c;
    w[6] = m_r; w[8] = m_o; w[9] = m_rs; w[10] = m_oc; w[12] = m_su;
    return w;
  endfunction

  function automatic string tag_of(int b);
    case (b)
      0: return "R1";  1, 3, 10: return "R2";  2: return "R3";  4: return "R10";
      6: return "R9";  8: return "R6";  9: return "R4";  12: return "R8";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    logic [15:0] exp;
    if (rst_n && m_valid) begin
      exp = model_word();
      checks++;
      for (int b = 0; b < 16; b++)
        if (rd_data[b] !== exp[b]) begin
          errors++;
          $display("FAIL %s model bit %0d: actual=%b expected=%b", tag_of(b), b, rd_data[b], exp[b]);
        end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 in reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset", rd_data, 16'h0000);
    dev_attach = 1; dev_low_speed = 1;
    @(negedge clk);
    chk("R1 connect and change", rd_data & 16'h0003, 16'h0003);
    chk("R10 low speed while connected", rd_data & 16'h0010, 16'h0010);
    wr(16'h0000);
    chk("R2 zero write keeps change", rd_data & 16'h0002, 16'h0002);
    wr(16'h0002);
    chk("R2 one write clears change", rd_data & 16'h0002, 16'h0000);
    wr(16'h0004);
    chk("R3 enable while connected", rd_data & 16'h0004, 16'h0004);
    wr(16'h0204);
    chk("R4 reset drops enable", rd_data & 16'h020C, 16'h0208);
    wr(16'h0000);
    chk("R5 reset release flags connect", rd_data & 16'h0202, 16'h0002);
    wr(16'h000A);
    chk("R2 clear both changes", rd_data & 16'h000A, 16'h0000);
    wr(16'h0040);
    chk("R7 resume blocked when disabled", rd_data & 16'h0040, 16'h0000);
    wr(16'h0004);
    wr(16'h1004);
    @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    chk("R8 wakeup sets resume", rd_data & 16'h1044, 16'h1044);
    wr(16'h0004);
    chk("R9 resume held after clear", rd_data & 16'h0040, 16'h0040);
    wr(16'h0044);
    repeat (CPU - 3) @(negedge clk);
    chk("R9 resume held mid end-of-packet", rd_data & 16'h0040, 16'h0040);
    repeat (2 * CPU + 2) @(negedge clk);
    chk("R9 resume cleared after end-of-packet", rd_data & 16'h0040, 16'h0000);
    oc_pin = 0;
    @(negedge clk);
    chk("R6 active-low pin reads overcurrent", rd_data & 16'h0500, 16'h0500);
    wr(16'h0404);
    chk("R2 clear overcurrent change", rd_data & 16'h0500, 16'h0100);
    oc_pin = 1;
    @(negedge clk);
    chk("R6 release flags change", rd_data & 16'h0500, 16'h0400);
    wr(16'hE8A4);
    chk("R11 reserved read zero", rd_data & 16'hE8A0, 16'h0000);
    dev_attach = 0;
    @(negedge clk);
    chk("R3 disconnect drops enable", rd_data & 16'h000F, 16'h000A);
    chk("R10 low speed hidden when detached", rd_data & 16'h0010, 16'h0000);
    @(negedge clk);
    dev_attach = 1; dev_low_speed = 0; wr_en = 1; wr_data = 16'h0002;
    @(negedge clk); wr_en = 0; wr_data = '0;
    chk("R2 set wins over clear", rd_data & 16'h0013, 16'h0003);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule